// File: doc/BRIEF.md
# Privileged Mode Entry and Cache-Policy Unit

This unit keeps track of whether a small processor runs in its privileged management mode. It also decides, for every memory access, whether the cache treats that access as uncacheable or as write-back. A management interrupt moves the processor into the privileged mode. On entry the unit issues a one-cycle redirect whose target is the protected base register plus a fixed entry offset (0x8000 by default). A resume strobe returns the processor to normal mode.

Two range registers describe a protected region. The base register holds an address and the privileged cache type. The mask register holds an address mask and a valid bit. Both can be written only while the privileged mode is active. Inside that region, accesses made in privileged mode use the programmed type, and accesses made outside it are always forced uncacheable. Every other address takes the default strategy that the requester supplies with the access.

All pins are plain control and status signals. The access address and the default strategy are looked up combinationally in the same cycle, and nothing is queued, so the unit has no valid/ready stream and applies no back-pressure. Instruction execution and the cache array lie outside the unit.

Top module: `mgmt_mode_unit`

## Requirements
- R1: After reset the unit is in normal mode (`priv_o`=0), `redir_vld_o`=0 and `rsm_err_o`=0. The range is invalid, so `strat_wb_o` follows `dflt_wb_i` for every address.
- R2: An interrupt sampled at a clock edge while in normal mode makes `priv_o` 1 after that edge. In that same cycle only, `redir_vld_o` is 1 and `redir_pc_o` is the base register value plus the entry offset.
- R3: An interrupt sampled while in privileged mode causes no redirect, and the unit stays in privileged mode.
- R4: An interrupt that arrives during privileged mode is held. It is accepted at the first edge after the resume takes effect, so `priv_o` is 0 for exactly one cycle and then returns to 1 with a redirect.
- R5: `rsm_i` sampled while in privileged mode makes `priv_o` 0 after that edge.
- R6: `rsm_i` sampled while in normal mode leaves the mode unchanged and raises `rsm_err_o` for exactly one cycle.
- R7: Range-register writes (`rr_wr_i`) sampled in normal mode change no register. This holds for both the base (`rr_sel_i`=0) and the mask (`rr_sel_i`=1).
- R8: An address hits the range when (address AND mask) equals (base AND mask) and the valid bit (`rr_attr_i` of a mask write) is 1. No address hits while the valid bit is 0.
- R9: On a hit, `strat_wb_o` is the programmed type (`rr_attr_i` of a base write; 1 = write-back, 0 = uncacheable) in privileged mode, and 0 in normal mode.
- R10: On a miss, `strat_wb_o` equals `dflt_wb_i` (1 = write-back, 0 = uncacheable).
- R11: The redirect target is base plus offset, taken modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_i | input | 1 | Management interrupt request |
| rsm_i | input | 1 | Resume strobe |
| rr_wr_i | input | 1 | Range-register write strobe |
| rr_sel_i | input | 1 | 0 = base register, 1 = mask register |
| rr_data_i | input | AW | Base address or mask value |
| rr_attr_i | input | 1 | Base write: type (1 = write-back); mask write: valid bit |
| acc_addr_i | input | AW | Access address to classify |
| dflt_wb_i | input | 1 | Default strategy for this access (1 = write-back) |
| priv_o | output | 1 | Privileged mode active |
| redir_vld_o | output | 1 | One-cycle redirect pulse on entry |
| redir_pc_o | output | AW | Redirect target |
| strat_wb_o | output | 1 | Chosen strategy (1 = write-back, 0 = uncacheable) |
| rsm_err_o | output | 1 | One-cycle flag for a resume in normal mode |

## Verification
The bench builds the unit with a 20-bit address, a base reset value of 0x30000 and the default entry offset of 0x8000. The narrow address makes the modulo wrap of the redirect target easy to reach: a base of 0xFC000 wraps to a target of 0x04000. A 64 KiB mask makes both edges of the region, and the addresses just outside them, cheap to probe. With the 0x30000 reset base, a redirect right after reset shows directly whether a base write attempted in normal mode was dropped.

// File: rtl/prv_pkg.sv
package prv_pkg;
  typedef enum logic {
    STRAT_UC = 1'b0,
    STRAT_WB = 1'b1
  } strat_e;

  typedef enum logic {
    MODE_NORM = 1'b0,
    MODE_PRIV = 1'b1
  } mode_e;

  typedef enum logic {
    RR_BASE = 1'b0,
    RR_MASK = 1'b1
  } rr_sel_e;
endpackage

// File: rtl/prv_mode_ctrl.sv
module prv_mode_ctrl
  import prv_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] OFS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smi_i,
  input  logic          rsm_i,
  input  logic [AW-1:0] entry_base_i,
  output logic          priv_o,
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_pc_o,
  output logic          rsm_err_o
);
  mode_e         mode_q;
  logic          pend_q;
  logic          redir_q;
  logic          err_q;
  logic [AW-1:0] pc_q;
  logic          take;

  // accept a fresh request or one held over from the privileged period
  assign take = (mode_q == MODE_NORM) && (smi_i || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORM;
      pend_q  <= 1'b0;
      redir_q <= 1'b0;
      err_q   <= 1'b0;
      pc_q    <= '0;
    end else begin
      redir_q <= 1'b0;
      err_q   <= rsm_i && (mode_q == MODE_NORM);
      if (take) begin
        mode_q  <= MODE_PRIV;
        redir_q <= 1'b1;
        pc_q    <= entry_base_i + OFS;
        pend_q  <= 1'b0;
      end else if (mode_q == MODE_PRIV) begin
        if (rsm_i) mode_q <= MODE_NORM;
        if (smi_i) pend_q <= 1'b1;
      end
    end
  end

  assign priv_o      = (mode_q == MODE_PRIV);
  assign redir_vld_o = redir_q;
  assign redir_pc_o  = pc_q;
  assign rsm_err_o   = err_q;
endmodule

// File: rtl/prv_range_regs.sv
module prv_range_regs
  import prv_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] BASE_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_i,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [AW-1:0] data_i,
  input  logic          attr_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] mask_o,
  output logic          type_wb_o,
  output logic          valid_o
);
  logic          wr_ok;
  logic [AW-1:0] base_q;
  logic [AW-1:0] mask_q;
  strat_e        type_q;
  logic          valid_q;

  assign wr_ok = wr_i && priv_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= BASE_INIT;
      mask_q  <= '0;
      type_q  <= STRAT_UC;
      valid_q <= 1'b0;
    end else if (wr_ok) begin
      if (rr_sel_e'(sel_i) == RR_BASE) begin
        base_q <= data_i;
        type_q <= strat_e'(attr_i);
      end else begin
        mask_q  <= data_i;
        valid_q <= attr_i;
      end
    end
  end

  assign base_o    = base_q;
  assign mask_o    = mask_q;
  assign type_wb_o = (type_q == STRAT_WB);
  assign valid_o   = valid_q;
endmodule

// File: rtl/prv_policy_sel.sv
module prv_policy_sel
  import prv_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic          valid_i,
  input  logic          type_wb_i,
  input  logic          priv_i,
  input  logic          dflt_wb_i,
  output logic          hit_o,
  output logic          wb_o
);
  logic [AW-1:0] bit_ok;

  for (genvar b = 0; b < AW; b++) begin : g_cmp
    assign bit_ok[b] = !mask_i[b] || (addr_i[b] == base_i[b]);
  end

  assign hit_o = valid_i && (&bit_ok);

  always_comb begin
    if (!hit_o)      wb_o = dflt_wb_i;
    else if (priv_i) wb_o = type_wb_i;
    else             wb_o = STRAT_UC;
  end
endmodule

// File: rtl/mgmt_mode_unit.sv
module mgmt_mode_unit
  import prv_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned ENTRY_OFS = 32'h8000,
  parameter int unsigned BASE_RST  = 32'h0003_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smi_i,
  input  logic          rsm_i,
  input  logic          rr_wr_i,
  input  logic          rr_sel_i,
  input  logic [AW-1:0] rr_data_i,
  input  logic          rr_attr_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          dflt_wb_i,
  output logic          priv_o,
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_pc_o,
  output logic          strat_wb_o,
  output logic          rsm_err_o
);
  localparam logic [AW-1:0] OFS_V  = AW'(ENTRY_OFS);
  localparam logic [AW-1:0] BASE_V = AW'(BASE_RST);

  logic          priv_w;
  logic [AW-1:0] rr_base;
  logic [AW-1:0] rr_mask;
  logic          rr_type_wb;
  logic          rr_valid;
  logic          range_hit;

  prv_mode_ctrl #(.AW(AW), .OFS(OFS_V)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .smi_i        (smi_i),
    .rsm_i        (rsm_i),
    .entry_base_i (rr_base),
    .priv_o       (priv_w),
    .redir_vld_o  (redir_vld_o),
    .redir_pc_o   (redir_pc_o),
    .rsm_err_o    (rsm_err_o)
  );

  prv_range_regs #(.AW(AW), .BASE_INIT(BASE_V)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_i    (priv_w),
    .wr_i      (rr_wr_i),
    .sel_i     (rr_sel_i),
    .data_i    (rr_data_i),
    .attr_i    (rr_attr_i),
    .base_o    (rr_base),
    .mask_o    (rr_mask),
    .type_wb_o (rr_type_wb),
    .valid_o   (rr_valid)
  );

  prv_policy_sel #(.AW(AW)) u_sel (
    .addr_i    (acc_addr_i),
    .base_i    (rr_base),
    .mask_i    (rr_mask),
    .valid_i   (rr_valid),
    .type_wb_i (rr_type_wb),
    .priv_i    (priv_w),
    .dflt_wb_i (dflt_wb_i),
    .hit_o     (range_hit),
    .wb_o      (strat_wb_o)
  );

  assign priv_o = priv_w;
endmodule

// File: rtl/prv_checker.sv
module prv_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smi_i,
  input logic          rsm_i,
  input logic          rr_wr_i,
  input logic          dflt_wb_i,
  input logic          priv_o,
  input logic          redir_vld_o,
  input logic          strat_wb_o,
  input logic          rsm_err_o,
  input logic          range_hit,
  input logic [AW-1:0] rr_base,
  input logic [AW-1:0] rr_mask,
  input logic          rr_valid
);
  AST_REDIR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> (priv_o && !$past(priv_o)));  // R2
  AST_ENTRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(priv_o) |-> redir_vld_o);  // R2
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_o && smi_i && !rsm_i) |=> (priv_o && !redir_vld_o));  // R3
  AST_RSM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_o && rsm_i) |=> !priv_o);  // R5
  AST_RSM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && rsm_i) |=> rsm_err_o);  // R6
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && rr_wr_i) |=> ($stable(rr_base) && $stable(rr_mask) && $stable(rr_valid)));  // R7
  AST_NORM_HIT_UC: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && range_hit) |-> !strat_wb_o);  // R9
  AST_MISS_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
    !range_hit |-> (strat_wb_o == dflt_wb_i));  // R10
endmodule

bind mgmt_mode_unit prv_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smi_i       (smi_i),
  .rsm_i       (rsm_i),
  .rr_wr_i     (rr_wr_i),
  .dflt_wb_i   (dflt_wb_i),
  .priv_o      (priv_o),
  .redir_vld_o (redir_vld_o),
  .strat_wb_o  (strat_wb_o),
  .rsm_err_o   (rsm_err_o),
  .range_hit   (range_hit),
  .rr_base     (rr_base),
  .rr_mask     (rr_mask),
  .rr_valid    (rr_valid)
);

// File: tb/test_mgmt_mode_unit.sv
module test_mgmt_mode_unit;
  localparam int unsigned AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smi_i, rsm_i, rr_wr_i, rr_sel_i, rr_attr_i, dflt_wb_i;
  logic [AW-1:0] rr_data_i, acc_addr_i;
  logic          priv_o, redir_vld_o, strat_wb_o, rsm_err_o;
  logic [AW-1:0] redir_pc_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  mgmt_mode_unit #(.AW(AW), .ENTRY_OFS(32'h8000), .BASE_RST(32'h30000)) i_mgmt_mode_unit (
    .clk(clk), .rst_n(rst_n), .smi_i(smi_i), .rsm_i(rsm_i), .rr_wr_i(rr_wr_i),
    .rr_sel_i(rr_sel_i), .rr_data_i(rr_data_i), .rr_attr_i(rr_attr_i),
    .acc_addr_i(acc_addr_i), .dflt_wb_i(dflt_wb_i), .priv_o(priv_o),
    .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o), .strat_wb_o(strat_wb_o),
    .rsm_err_o(rsm_err_o)
  );

  // table entry: {req number, want privileged, address, default, expected strategy}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV][5] = '{
    '{9,  1, 32'h41234, 0, 1},   // R9 hit, privileged -> type WB
    '{9,  1, 32'h4FFFF, 0, 1},   // R9 top edge of region
    '{10, 1, 32'h50000, 0, 0},   // R10 just above region
    '{10, 1, 32'h3FFFF, 1, 1},   // R10 just below region
    '{9,  0, 32'h41234, 1, 0},   // R9 hit, normal mode -> UC
    '{9,  0, 32'h40000, 1, 0},   // R9 bottom edge, normal mode
    '{10, 0, 32'h50000, 1, 1},   // R10 miss, default WB
    '{10, 0, 32'h00010, 0, 0}    // R10 miss, default UC
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_smi();
    smi_i = 1'b1; tick(); smi_i = 1'b0;
  endtask

  task automatic do_rsm();
    rsm_i = 1'b1; tick(); rsm_i = 1'b0;
  endtask

  task automatic wr_rr(input logic sel, input logic [AW-1:0] d, input logic a);
    rr_wr_i = 1'b1; rr_sel_i = sel; rr_data_i = d; rr_attr_i = a;
    tick();
    rr_wr_i = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic d);
    acc_addr_i = a; dflt_wb_i = d; #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smi_i = 0; rsm_i = 0; rr_wr_i = 0; rr_sel_i = 0;
    rr_data_i = '0; rr_attr_i = 0; acc_addr_i = '0; dflt_wb_i = 0;
    @(negedge clk);
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 priv", priv_o, 0);
    chk("R1 redir", redir_vld_o, 0);
    chk("R1 err", rsm_err_o, 0);
    look(20'h30000, 1); chk("R1 strat dflt1", strat_wb_o, 1);
    look(20'h30000, 0); chk("R1 strat dflt0", strat_wb_o, 0);

    // R7 writes in normal mode are dropped
    wr_rr(1'b0, 20'h40000, 1'b1);
    wr_rr(1'b1, 20'hF0000, 1'b1);

    // R2 entry, redirect from the unchanged reset base
    do_smi();
    chk("R2 priv", priv_o, 1);
    chk("R2 redir_vld", redir_vld_o, 1);
    chk("R7 base kept: redir_pc", redir_pc_o, 32'h38000);
    look(20'h40000, 0); chk("R7 mask/valid kept", strat_wb_o, 0);
    tick();
    chk("R2 pulse one cycle", redir_vld_o, 0);

    // R3 non-reentrant, request held
    do_smi();
    chk("R3 no redirect", redir_vld_o, 0);
    chk("R3 still priv", priv_o, 1);
    // R5 resume, R4 held request taken one cycle later
    do_rsm();
    chk("R5 left priv", priv_o, 0);
    chk("R4 no redirect yet", redir_vld_o, 0);
    tick();
    chk("R4 re-entered", priv_o, 1);
    chk("R4 redirect", redir_vld_o, 1);

    // program range in privileged mode
    wr_rr(1'b0, 20'h40000, 1'b1);
    wr_rr(1'b1, 20'hF0000, 1'b1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][1][0] != priv_o) begin
        if (priv_o) do_rsm(); else do_smi();
        tick();
      end
      look(VEC[i][2][AW-1:0], VEC[i][3][0]);
      tests++;
      if (strat_wb_o !== VEC[i][4][0]) begin
        fails++;
        $display("FAIL R%0d vec %0d actual=%0h expected=%0h", VEC[i][0], i, strat_wb_o, VEC[i][4][0]);
      end
    end

    // R6 resume in normal mode
    do_rsm();
    chk("R6 err", rsm_err_o, 1);
    chk("R6 mode kept", priv_o, 0);
    tick();
    chk("R6 err one cycle", rsm_err_o, 0);

    // R11 redirect from programmed base, then wrap
    do_smi();
    chk("R11 pc", redir_pc_o, 32'h48000);
    wr_rr(1'b0, 20'hFC000, 1'b1);
    do_rsm();
    do_smi();
    chk("R11 wrap pc", redir_pc_o, 32'h04000);

    // R8 valid bit gates the match
    wr_rr(1'b1, 20'hF0000, 1'b0);
    look(20'hF1234, 0); chk("R8 invalid no hit", strat_wb_o, 0);
    wr_rr(1'b1, 20'hF0000, 1'b1);
    look(20'hF1234, 0); chk("R8 valid hit", strat_wb_o, 1);

    // R7 mask write in normal mode has no effect
    do_rsm();
    wr_rr(1'b1, 20'hF0000, 1'b0);
    do_smi();
    look(20'hF1234, 0); chk("R7 valid kept", strat_wb_o, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule